// File: doc/BRIEF.md
# Wave Fetch Eligibility Arbiter

This block sits in front of the instruction fetch path of a compute core that holds several hardware thread groups (waves). Every cycle it looks at each wave that is not already waiting in its ready queue. It decides whether that wave may ask for more instructions: the wave must be running, must have room in its instruction buffer, must have no branch in that buffer (so no fetch is ever speculative), and must have no fetch already in flight. Waves that pass are appended to an ordered ready queue. When several pass in the same cycle, they go in by ascending index.

In each cycle the oldest queued wave, if any, is granted. The grant is registered and appears on `grant_valid_o`/`grant_idx_o` for one cycle. Granting a wave marks its fetch as outstanding. That mark stays until the fetch path returns a completion pulse carrying the wave's index. Address generation and the memory access itself belong to the downstream logic.

Top module: `fetch_wave_arb`

## Requirements
- R1: A wave is appended to the ready queue only when its 2-bit status equals the running code 2'd1. The codes 2'd0, 2'd2 and 2'd3 never qualify.
- R2: A wave is appended only when its buffer occupancy is at most OCC_LIMIT (default 4). An occupancy of 4 qualifies and an occupancy of 5 or more does not.
- R3: A wave whose branch-present input is 1 is not appended.
- R4: A wave with an outstanding fetch is not appended, so a wave that stays eligible is granted only once until its completion arrives.
- R5: Once a wave is queued it is not re-evaluated. It is granted later even if its status, occupancy or branch input has since changed.
- R6: Granting a wave sets its outstanding-fetch flag. A `done_valid_i` pulse clears that flag for the wave in `done_idx_i`. A completion for a wave with no outstanding fetch has no effect.
- R7: Grants leave the queue oldest-first. Waves appended in the same cycle are ordered by ascending index. The queue never holds more than N_WAVES entries, and the granted index is always below N_WAVES.
- R8: At most one grant is issued per cycle, and none when the queue is empty. A wave appended into an empty queue is granted on the clock edge that samples its eligible inputs.
- R9: After reset, no grant is asserted, the queue is empty and no wave has a fetch outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wave_status_i | input | 2*N_WAVES | Per-wave status, 2 bits per wave, wave j at bits [2j+1:2j] |
| buf_occ_i | input | OCC_W*N_WAVES | Per-wave instruction buffer occupancy |
| has_branch_i | input | N_WAVES | Per-wave branch-present flag |
| done_valid_i | input | 1 | Fetch completion pulse |
| done_idx_i | input | IDX_W | Wave index of the completion |
| grant_valid_o | output | 1 | A wave is granted this cycle |
| grant_idx_o | output | IDX_W | Index of the granted wave |

## Verification
The bench builds the arbiter with N_WAVES = 6, OCC_W = 4 and OCC_LIMIT = 4. Six waves is not a power of two, so the queue-full case (all six appended in one cycle) uses a count that does not wrap the index width. A 4-bit occupancy reaches values well past the limit, which exercises the boundary at 4 versus 5. The small wave count lets a full drain, cross-cycle ordering and stale queued entries all fit into short scenarios checked by a scoreboard of expected grant indices.

// File: rtl/fetch_arb_pkg.sv
package fetch_arb_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    WS_IDLE = 2'd0,
    WS_RUN  = 2'd1,
    WS_WAIT = 2'd2,
    WS_DONE = 2'd3
  } wave_state_e;

endpackage

// File: rtl/fetch_elig_scan.sv
module fetch_elig_scan
  import fetch_arb_pkg::*;
#(
  parameter int N_WAVES   = 8,
  parameter int OCC_W     = 4,
  parameter int OCC_LIMIT = 4
) (
  input  logic [STATE_W*N_WAVES-1:0] status_i,
  input  logic [OCC_W*N_WAVES-1:0]   occ_i,
  input  logic [N_WAVES-1:0]         branch_i,
  input  logic [N_WAVES-1:0]         queued_i,
  input  logic [N_WAVES-1:0]         pending_i,
  output logic [N_WAVES-1:0]         elig_o
);

  localparam logic [OCC_W-1:0] OccMax = OCC_W'(OCC_LIMIT);

  for (genvar j = 0; j < N_WAVES; j++) begin : g_wave
    logic running, room;
    assign running   = (status_i[j*STATE_W +: STATE_W] == WS_RUN);
    assign room      = (occ_i[j*OCC_W +: OCC_W] <= OccMax);
    // queued waves are skipped: eligibility is not re-evaluated
    assign elig_o[j] = running && room && !branch_i[j] &&
                       !queued_i[j] && !pending_i[j];
  end

endmodule

// File: rtl/fetch_ready_fifo.sv
module fetch_ready_fifo #(
  parameter int N_WAVES = 8,
  localparam int IDX_W  = $clog2(N_WAVES),
  localparam int CNT_W  = $clog2(N_WAVES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_WAVES-1:0] push_i,
  output logic             pop_valid_o,
  output logic [IDX_W-1:0] pop_idx_o
);

  logic [IDX_W-1:0] q_r   [N_WAVES];
  logic [IDX_W-1:0] tmp_q [N_WAVES];
  logic [IDX_W-1:0] q_n   [N_WAVES];
  logic [CNT_W-1:0] cnt_r, cnt_n, fill;

  // append in ascending index order, then pop head of the merged queue
  always_comb begin
    for (int k = 0; k < N_WAVES; k++) tmp_q[k] = q_r[k];
    fill = cnt_r;
    for (int j = 0; j < N_WAVES; j++) begin
      if (push_i[j] && (fill < CNT_W'(N_WAVES))) begin
        tmp_q[IDX_W'(fill)] = IDX_W'(j);
        fill = fill + CNT_W'(1);
      end
    end
    pop_valid_o = (fill != '0);
    pop_idx_o   = tmp_q[0];
    for (int k = 0; k < N_WAVES - 1; k++)
      q_n[k] = pop_valid_o ? tmp_q[k+1] : tmp_q[k];
    q_n[N_WAVES-1] = pop_valid_o ? '0 : tmp_q[N_WAVES-1];
    cnt_n = pop_valid_o ? fill - CNT_W'(1) : fill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_r <= '0;
      for (int k = 0; k < N_WAVES; k++) q_r[k] <= '0;
    end else begin
      cnt_r <= cnt_n;
      for (int k = 0; k < N_WAVES; k++) q_r[k] <= q_n[k];
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_r <= CNT_W'(N_WAVES));

  p_empty_after_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cnt_r == '0));

endmodule

// File: rtl/fetch_wave_flags.sv
module fetch_wave_flags #(
  parameter int N_WAVES = 8,
  localparam int IDX_W  = $clog2(N_WAVES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_WAVES-1:0] push_i,
  input  logic               grant_v_i,
  input  logic [IDX_W-1:0]   grant_idx_i,
  input  logic               done_v_i,
  input  logic [IDX_W-1:0]   done_idx_i,
  output logic [N_WAVES-1:0] queued_o,
  output logic [N_WAVES-1:0] pending_o
);

  logic [N_WAVES-1:0] queued_r, pend_r;

  for (genvar j = 0; j < N_WAVES; j++) begin : g_flag
    logic hit_grant, hit_done;
    assign hit_grant = grant_v_i && (grant_idx_i == IDX_W'(j));
    assign hit_done  = done_v_i  && (done_idx_i  == IDX_W'(j));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        queued_r[j] <= 1'b0;
        pend_r[j]   <= 1'b0;
      end else begin
        // a wave appended and popped in the same cycle never stays queued
        queued_r[j] <= (queued_r[j] | push_i[j]) & ~hit_grant;
        // set on grant wins over a same-cycle completion
        pend_r[j]   <= hit_grant | (pend_r[j] & ~hit_done);
      end
    end
  end

  assign queued_o  = queued_r;
  assign pending_o = pend_r;

  p_grant_not_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_v_i |-> !pend_r[grant_idx_i]);

  p_grant_sets_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_v_i |=> pend_r[$past(grant_idx_i)]);

  p_push_not_queued_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(push_i & queued_r) == 0);

endmodule

// File: rtl/fetch_wave_arb.sv
module fetch_wave_arb
  import fetch_arb_pkg::*;
#(
  parameter int N_WAVES   = 8,
  parameter int OCC_W     = 4,
  parameter int OCC_LIMIT = 4,
  localparam int IDX_W    = $clog2(N_WAVES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [STATE_W*N_WAVES-1:0]   wave_status_i,
  input  logic [OCC_W*N_WAVES-1:0]     buf_occ_i,
  input  logic [N_WAVES-1:0]           has_branch_i,
  input  logic                         done_valid_i,
  input  logic [IDX_W-1:0]             done_idx_i,
  output logic                         grant_valid_o,
  output logic [IDX_W-1:0]             grant_idx_o
);

  logic [N_WAVES-1:0] elig, queued, pending;
  logic               pop_v;
  logic [IDX_W-1:0]   pop_idx;

  fetch_elig_scan #(
    .N_WAVES  (N_WAVES),
    .OCC_W    (OCC_W),
    .OCC_LIMIT(OCC_LIMIT)
  ) i_scan (
    .status_i (wave_status_i),
    .occ_i    (buf_occ_i),
    .branch_i (has_branch_i),
    .queued_i (queued),
    .pending_i(pending),
    .elig_o   (elig)
  );

  fetch_ready_fifo #(
    .N_WAVES(N_WAVES)
  ) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (elig),
    .pop_valid_o(pop_v),
    .pop_idx_o  (pop_idx)
  );

  fetch_wave_flags #(
    .N_WAVES(N_WAVES)
  ) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (elig),
    .grant_v_i  (pop_v),
    .grant_idx_i(pop_idx),
    .done_v_i   (done_valid_i),
    .done_idx_i (done_idx_i),
    .queued_o   (queued),
    .pending_o  (pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_idx_o   <= '0;
    end else begin
      grant_valid_o <= pop_v;
      grant_idx_o   <= pop_v ? pop_idx : grant_idx_o;
    end
  end

  p_grant_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (int'(grant_idx_o) < N_WAVES));

  p_grant_marks_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> pending[grant_idx_o]);

endmodule

// File: tb/test_fetch_wave_arb.sv
module test_fetch_wave_arb;

  localparam int N     = 6;
  localparam int OCCW  = 4;
  localparam int IDXW  = $clog2(N);
  localparam logic [1:0] RUN = 2'd1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2*N-1:0]    status = '0;
  logic [OCCW*N-1:0] occ = '0;
  logic [N-1:0]      br = '0;
  logic              done_v = 1'b0;
  logic [IDXW-1:0]   done_idx = '0;
  logic              gv;
  logic [IDXW-1:0]   gidx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int    exp_idx [$];
  string exp_tag [$];

  always #5 clk = ~clk;

  fetch_wave_arb #(.N_WAVES(N), .OCC_W(OCCW), .OCC_LIMIT(4)) i_fetch_wave_arb (
    .clk_i(clk), .rst_ni(rst_n), .wave_status_i(status), .buf_occ_i(occ),
    .has_branch_i(br), .done_valid_i(done_v), .done_idx_i(done_idx),
    .grant_valid_o(gv), .grant_idx_o(gidx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_grant(input int idx, input string tag);
    exp_idx.push_back(idx);
    exp_tag.push_back(tag);
  endtask

  // monitor: compare each grant with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && gv && !finished) begin
      if (exp_idx.size() == 0) begin
        check(1'b0, "R8 unexpected grant", int'(gidx), -1);
      end else begin
        int e;
        string t;
        e = exp_idx.pop_front();
        t = exp_tag.pop_front();
        check(int'(gidx) == e, t, int'(gidx), e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_wave(input int j, input logic [1:0] st, input int o, input bit b);
    status[2*j +: 2]     = st;
    occ[OCCW*j +: OCCW]  = OCCW'(o);
    br[j]                = b;
  endtask

  task automatic idle_all();
    status = '0; occ = '0; br = '0;
  endtask

  task automatic done_pulse(input int j);
    done_v = 1'b1; done_idx = IDXW'(j);
    step(1);
    done_v = 1'b0;
  endtask

  task automatic release_all();
    for (int j = 0; j < N; j++) done_pulse(j);
  endtask

  task automatic drained(input string tag);
    step(N + 2);
    check(exp_idx.size() == 0, tag, exp_idx.size(), 0);
    exp_idx.delete(); exp_tag.delete();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    check(gv == 1'b0, "R9 grant low after reset", int'(gv), 0);
    step(3);
    check(gv == 1'b0, "R9 no grant with idle waves", int'(gv), 0);

    // R1: non-running codes never qualify
    set_wave(0, 2'd0, 0, 0); set_wave(1, 2'd2, 0, 0); set_wave(2, 2'd3, 0, 0);
    step(4);
    check(gv == 1'b0, "R1 non-running waves not granted", int'(gv), 0);
    set_wave(3, RUN, 1, 0);
    expect_grant(3, "R1 running wave granted");
    step(1);
    // R8: granted at the edge that sampled the eligible inputs
    check(gv == 1'b1 && gidx == 3, "R8 grant one edge after eligibility", int'(gv), 1);
    idle_all();
    drained("R1 scenario drained");
    release_all();

    // R2: occupancy boundary
    set_wave(1, RUN, 5, 0); set_wave(2, RUN, 4, 0); set_wave(4, RUN, 15, 0);
    expect_grant(2, "R2 occupancy 4 qualifies, 5 and 15 do not");
    step(4);
    idle_all();
    drained("R2 scenario drained");
    release_all();

    // R3: branch blocks
    set_wave(0, RUN, 0, 1); set_wave(4, RUN, 0, 0);
    expect_grant(4, "R3 branch-free wave granted, branch wave skipped");
    step(4);
    idle_all();
    drained("R3 scenario drained");
    release_all();

    // R7: all waves in one cycle, ascending order, full queue
    for (int j = 0; j < N; j++) begin
      set_wave(j, RUN, 0, 0);
      expect_grant(j, "R7 same-cycle appends ascending");
    end
    step(1);
    idle_all();
    drained("R7 full queue drained");
    release_all();

    // R4/R6: held-eligible wave granted once until its completion
    set_wave(5, RUN, 2, 0);
    expect_grant(5, "R4 first grant of held wave");
    step(6);
    done_pulse(2);
    step(3);
    check(exp_idx.size() == 0, "R6 foreign completion has no effect", exp_idx.size(), 0);
    expect_grant(5, "R6 regrant after own completion");
    done_pulse(5);
    step(3);
    idle_all();
    done_pulse(5);
    drained("R4 scenario drained");

    // R5: queued waves are not rechecked
    set_wave(1, RUN, 0, 0); set_wave(2, RUN, 0, 0); set_wave(3, RUN, 0, 0);
    expect_grant(1, "R5 first queued wave");
    expect_grant(2, "R5 stale entry granted after status drop");
    expect_grant(3, "R5 stale entry granted after branch appears");
    step(1);
    idle_all();
    set_wave(3, RUN, 9, 1);
    step(1);
    idle_all();
    drained("R5 scenario drained");
    release_all();

    // R7: oldest-first across cycles beats index order
    set_wave(4, RUN, 0, 0); set_wave(5, RUN, 0, 0);
    expect_grant(4, "R7 oldest first (4)");
    expect_grant(5, "R7 oldest first (5)");
    expect_grant(0, "R7 later low index waits (0)");
    step(1);
    idle_all();
    set_wave(0, RUN, 0, 0);
    step(1);
    idle_all();
    drained("R7 cross-cycle drained");
    release_all();
    step(2);
    check(gv == 1'b0, "R8 idle at end", int'(gv), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule